// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core and arbitrates five hardware interrupt request lines. Every line has its own trigger mode and its own maskability. The top line cannot be masked. It needs a fresh rising edge, and its level must still be high when the core takes it. Below it sit one edge-latched line, two plain level lines and a lowest line that carries no vector. For that lowest line the device supplies the service address after an acknowledge pulse. The block also turns a 3-bit software restart number into its vector.

The core watches `irq_pend`. When it decides to take an interrupt it pulses `take` for one cycle. The block then captures the winning line's service vector and shows it on `irq_vec`, with `vec_vld` high for one cycle. For the lowest line it first raises `inta` for one cycle and samples `dev_addr` during that cycle. Taking any interrupt clears the global enable. Software turns it back on with `ien_set`. Saving the return address and fetching code belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_req` bit 4 is the unmaskable line, bit 3 the edge-latched line, bits 2 and 1 the level lines, and bit 0 the device-addressed line. When several lines are pending, the highest bit number wins.
- R2: The bit-4 line is recognised whatever the state of the global enable and the mask bits.
- R3: The bit-4 line pends only after a rising edge on it, and only while it is still high. Holding it high after it has been taken raises no new request.
- R4: A recognised bit-4 edge stays latched until that line is taken or the block is reset. A drop and a later rise with no new edge in between are not enough on their own; a fresh rising edge re-arms it.
- R5: `mask_wr` loads `mask_data` as follows: bit 3 masks line 3, bit 2 masks line 2, bit 1 masks line 1 and bit 0 masks line 0. A mask bit of 0 lets the request through. After reset all four mask bits are 1.
- R6: Lines 2 and 1 are level-triggered and have no latch. A request that goes away before it is taken leaves nothing pending.
- R7: A rising edge on line 3 is latched even while that line is masked. The latch is cleared when line 3 is taken, by reset, or by `mask_wr` with `mask_clr_edge` high. A clear wins over a same-cycle edge.
- R8: The cycle after an accepted take of a vectored line, `vec_vld` is high for one cycle and `irq_vec` holds the line's vector: 16'h0024 for line 4, 16'h003C for line 3, 16'h0034 for line 2, 16'h002C for line 1. `irq_vec` keeps its value until the next capture.
- R9: When line 0 wins a take, `inta` is high for exactly the next cycle. `dev_addr` is sampled at the end of that cycle and appears on `irq_vec`, with `vec_vld` high, in the cycle after it. While `inta` is high, `irq_pend` is low and `take` is ignored.
- R10: `sw_vec` equals `sw_num` times 8, zero-extended, combinationally.
- R11: After reset the global enable is 0, and only line 4 can pend while it is 0. `ien_set` sets it. Any accepted take clears it, and the clear wins over a same-cycle `ien_set`. A `take` while nothing is pending has no effect.
- R12: After reset `irq_pend`, `inta`, `vec_vld` and `irq_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Request lines, bit 4 highest priority |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 4 | New mask bits for lines 3..0 (1 = masked) |
| mask_clr_edge | input | 1 | With `mask_wr`, clears the line-3 edge latch |
| ien_set | input | 1 | Sets the global enable |
| take | input | 1 | Core accepts the pending interrupt |
| dev_addr | input | VEC_W | Service address driven by the device while `inta` is high |
| sw_num | input | 3 | Software restart number |
| irq_pend | output | 1 | An interrupt is pending |
| irq_vec | output | VEC_W | Captured service vector |
| vec_vld | output | 1 | `irq_vec` was just captured |
| inta | output | 1 | Acknowledge strobe for line 0 |
| sw_vec | output | VEC_W | Vector of the software restart number |

## Verification
The assertions check several rules on every cycle. The acknowledge is a single-cycle pulse that only an accepted take can cause. Every `vec_vld` has a take or an acknowledge behind it. The global enable falls after each accepted take. Nothing but a high line 4 can pend while the enable is off. The priority order, the exact vector values, the edge and level behaviour of lines 4 and 3, the mask clear and the device-address capture depend on stimulus history. Only the bench's scenarios, compared against its behavioural model every cycle, can show those.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned N_LINES = 5;
   localparam int unsigned IDX_DEV  = 0;
   localparam int unsigned IDX_LV1  = 1;
   localparam int unsigned IDX_LV2  = 2;
   localparam int unsigned IDX_EDGE = 3;
   localparam int unsigned IDX_NMI  = 4;
   localparam int unsigned RST_NUM_W = 3;

   function automatic logic [15:0] line_vector(input logic [N_LINES-1:0] grant);
      logic [15:0] v;
      v = 16'h0000;
      if (grant[IDX_NMI])  v = 16'h0024;
      if (grant[IDX_EDGE]) v = 16'h003C;
      if (grant[IDX_LV2])  v = 16'h0034;
      if (grant[IDX_LV1])  v = 16'h002C;
      return v;
   endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter bit NEED_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic clr,
   output logic pend
);
   logic prev_q;
   logic lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= line;
         if (clr)
            lat_q <= 1'b0;
         else if (line && !prev_q)
            lat_q <= 1'b1;
      end
   end

   generate
      if (NEED_LEVEL) begin : g_level
         assign pend = lat_q & line;
      end else begin : g_edge
         assign pend = lat_q;
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] above;

   assign above[N] = 1'b0;
   generate
      for (genvar i = N - 1; i >= 0; i--) begin : g_stage
         assign grant[i]   = req[i] & ~above[i+1];
         assign above[i]   = above[i+1] | req[i];
      end
   endgenerate
   assign any = above[0];
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
   parameter int unsigned VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_ok,
   input  logic             to_dev,
   input  logic [VEC_W-1:0] fixed_vec,
   input  logic [VEC_W-1:0] dev_addr,
   output logic             inta,
   output logic [VEC_W-1:0] vec,
   output logic             vld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inta <= 1'b0;
         vld  <= 1'b0;
         vec  <= '0;
      end else begin
         inta <= take_ok & to_dev;
         vld  <= (take_ok & ~to_dev) | inta;
         if (take_ok && !to_dev)
            vec <= fixed_vec;
         else if (inta)
            vec <= dev_addr;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int unsigned VEC_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [irq_pkg::N_LINES-1:0]     irq_req,
   input  logic                            mask_wr,
   input  logic [irq_pkg::N_LINES-2:0]     mask_data,
   input  logic                            mask_clr_edge,
   input  logic                            ien_set,
   input  logic                            take,
   input  logic [VEC_W-1:0]                dev_addr,
   input  logic [irq_pkg::RST_NUM_W-1:0]   sw_num,
   output logic                            irq_pend,
   output logic [VEC_W-1:0]                irq_vec,
   output logic                            vec_vld,
   output logic                            inta,
   output logic [VEC_W-1:0]                sw_vec
);
   import irq_pkg::*;

   localparam int unsigned NM    = N_LINES - 1;
   localparam int unsigned SHIFT = 3;
   localparam int unsigned PAD_W = VEC_W - RST_NUM_W - SHIFT;

   generate
      if (VEC_W < 16) begin : g_bad_width
         $error("prio_irq_ctrl: VEC_W must be at least 16");
      end
   endgenerate

   logic [NM-1:0]      mask_q;
   logic               ien_q;
   logic               nmi_pend;
   logic               edge_pend;
   logic [N_LINES-1:0] cand;
   logic [N_LINES-1:0] grant;
   logic               any;
   logic               take_ok;
   logic [VEC_W-1:0]   fixed_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         ien_q  <= 1'b0;
      end else begin
         if (mask_wr)
            mask_q <= mask_data;
         if (take_ok)
            ien_q <= 1'b0;
         else if (ien_set)
            ien_q <= 1'b1;
      end
   end

   irq_edge_latch #(.NEED_LEVEL(1'b1)) u_nmi (
      .clk  (clk),
      .rst_n(rst_n),
      .line (irq_req[IDX_NMI]),
      .clr  (take_ok & grant[IDX_NMI]),
      .pend (nmi_pend)
   );

   irq_edge_latch #(.NEED_LEVEL(1'b0)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .line (irq_req[IDX_EDGE]),
      .clr  ((take_ok & grant[IDX_EDGE]) | (mask_wr & mask_clr_edge)),
      .pend (edge_pend)
   );

   always_comb begin
      cand           = '0;
      cand[IDX_NMI]  = nmi_pend;
      cand[IDX_EDGE] = edge_pend & ~mask_q[IDX_EDGE] & ien_q;
      cand[IDX_LV2]  = irq_req[IDX_LV2] & ~mask_q[IDX_LV2] & ien_q;
      cand[IDX_LV1]  = irq_req[IDX_LV1] & ~mask_q[IDX_LV1] & ien_q;
      cand[IDX_DEV]  = irq_req[IDX_DEV] & ~mask_q[IDX_DEV] & ien_q;
   end

   irq_prio_sel #(.N(N_LINES)) u_sel (
      .req  (cand),
      .grant(grant),
      .any  (any)
   );

   assign take_ok   = take & any & ~inta;
   assign irq_pend  = any & ~inta;
   assign fixed_vec = {{(VEC_W-16){1'b0}}, line_vector(grant)};

   irq_ack_seq #(.VEC_W(VEC_W)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_ok  (take_ok),
      .to_dev   (grant[IDX_DEV]),
      .fixed_vec(fixed_vec),
      .dev_addr (dev_addr),
      .inta     (inta),
      .vec      (irq_vec),
      .vld      (vec_vld)
   );

   assign sw_vec = {{PAD_W{1'b0}}, sw_num, {SHIFT{1'b0}}};
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] irq_req,
   input logic       take,
   input logic       irq_pend,
   input logic       inta,
   input logic       vec_vld,
   input logic       ien_q
);
   // R9: acknowledge lasts exactly one cycle
   a_r9_inta_single: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> !inta);

   // R9: acknowledge only follows an accepted take
   a_r9_inta_cause: assert property (@(posedge clk) disable iff (!rst_n)
      inta |-> $past(take && irq_pend));

   // R8: a captured vector always has a take or an acknowledge behind it
   a_r8_vld_cause: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> ($past(take && irq_pend) || $past(inta)));

   // R11: an accepted take drops the global enable
   a_r11_ien_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_pend) |=> !ien_q);

   // R11: with the enable off only a high line 4 can pend
   a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !ien_q) |-> irq_req[4]);

   // R3: line 4 pends only while its level is high
   a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !irq_req[4]) |-> ien_q);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_req (irq_req),
   .take    (take),
   .irq_pend(irq_pend),
   .inta    (inta),
   .vec_vld (vec_vld),
   .ien_q   (ien_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  irq_req = '0;
   logic        mask_wr = 1'b0;
   logic [3:0]  mask_data = '0;
   logic        mask_clr_edge = 1'b0;
   logic        ien_set = 1'b0;
   logic        take = 1'b0;
   logic [15:0] dev_addr = '0;
   logic [2:0]  sw_num = '0;
   logic        irq_pend;
   logic [15:0] irq_vec;
   logic        vec_vld;
   logic        inta;
   logic [15:0] sw_vec;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   string tag = "R12";

   always #2.5 clk = ~clk;

   prio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_wr(mask_wr),
      .mask_data(mask_data), .mask_clr_edge(mask_clr_edge), .ien_set(ien_set),
      .take(take), .dev_addr(dev_addr), .sw_num(sw_num), .irq_pend(irq_pend),
      .irq_vec(irq_vec), .vec_vld(vec_vld), .inta(inta), .sw_vec(sw_vec)
   );

   // behavioural reference model
   bit m_tlat, m_tprev, m_elat, m_eprev, m_ien, m_inta, m_vld;
   bit [3:0]  m_mask = 4'hF;
   bit [15:0] m_vec;

   function automatic int pick();
      if (m_tlat && irq_req[4]) return 4;
      if (!m_ien) return -1;
      if (m_elat && !m_mask[3]) return 3;
      if (irq_req[2] && !m_mask[2]) return 2;
      if (irq_req[1] && !m_mask[1]) return 1;
      if (irq_req[0] && !m_mask[0]) return 0;
      return -1;
   endfunction

   function automatic bit [15:0] vec_of(int s);
      case (s)
         4: return 16'h0024;
         3: return 16'h003C;
         2: return 16'h0034;
         default: return 16'h002C;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tlat = 0; m_tprev = 0; m_elat = 0; m_eprev = 0;
         m_ien = 0; m_inta = 0; m_vld = 0; m_vec = 0; m_mask = 4'hF;
      end else begin
         int s;
         bit tk;
         s  = pick();
         tk = take && (s >= 0) && !m_inta;
         m_vld = (tk && s != 0) || m_inta;
         if (tk && s != 0) m_vec = vec_of(s);
         else if (m_inta) m_vec = dev_addr;
         m_inta = tk && (s == 0);
         if (tk && s == 4) m_tlat = 0;
         else if (irq_req[4] && !m_tprev) m_tlat = 1;
         if ((tk && s == 3) || (mask_wr && mask_clr_edge)) m_elat = 0;
         else if (irq_req[3] && !m_eprev) m_elat = 1;
         if (tk) m_ien = 0;
         else if (ien_set) m_ien = 1;
         if (mask_wr) m_mask = mask_data;
         m_tprev = irq_req[4];
         m_eprev = irq_req[3];
      end
   end

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("irq_pend", {15'd0, irq_pend}, {15'd0, (pick() >= 0) && !m_inta});
      chk("inta", {15'd0, inta}, {15'd0, m_inta});
      chk("vec_vld", {15'd0, vec_vld}, {15'd0, m_vld});
      chk("irq_vec", irq_vec, m_vec);
      chk("sw_vec", sw_vec, {10'd0, sw_num, 3'b000});
   endtask

   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         #1 check_all();
      end
   endtask

   task automatic pulse_take();
      take = 1'b1; cyc(); take = 1'b0;
   endtask

   task automatic wr_mask(input logic [3:0] m, input logic clr);
      mask_wr = 1'b1; mask_data = m; mask_clr_edge = clr; cyc();
      mask_wr = 1'b0; mask_clr_edge = 1'b0;
   endtask

   task automatic enable();
      ien_set = 1'b1; cyc(); ien_set = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R12 reset state
      tag = "R12";
      cyc(2);
      rst_n = 1'b1;
      cyc(2);

      // R10 software restart vectors
      tag = "R10";
      for (int n = 0; n < 8; n++) begin
         sw_num = n[2:0];
         cyc();
      end
      sw_num = 3'd4; cyc();

      // R11 nothing pends while disabled, take with nothing pending ignored
      tag = "R11";
      irq_req = 5'b00111; cyc(2);
      wr_mask(4'h0, 1'b0); cyc();
      pulse_take(); cyc();

      // R1 priority among level lines
      tag = "R1";
      enable(); cyc();
      pulse_take(); cyc();
      tag = "R11";
      ien_set = 1'b1; take = 1'b1; cyc(); ien_set = 1'b0; take = 1'b0;
      cyc();

      // R5 masking line 2 lets line 1 win
      tag = "R5";
      wr_mask(4'b0100, 1'b0);
      enable(); pulse_take(); cyc();
      wr_mask(4'b0110, 1'b0);
      enable(); cyc(); pulse_take(); cyc();

      // R6 level line pulse with no latch
      tag = "R6";
      irq_req = 5'b00000; wr_mask(4'b1000, 1'b0); enable();
      irq_req = 5'b00100; cyc(); irq_req = 5'b00000; cyc(2);
      pulse_take(); cyc();

      // R7 edge line latched while masked, then unmasked
      tag = "R7";
      wr_mask(4'b1111, 1'b0);
      irq_req = 5'b01000; cyc(); irq_req = 5'b00000; cyc(2);
      wr_mask(4'b0111, 1'b0); cyc();
      tag = "R8";
      pulse_take(); cyc(2);
      tag = "R7";
      enable();
      irq_req = 5'b01000; cyc(); irq_req = 5'b00000; cyc();
      wr_mask(4'b0111, 1'b1); cyc(2);
      irq_req = 5'b01000; mask_wr = 1'b1; mask_data = 4'b0111; mask_clr_edge = 1'b1;
      cyc(); mask_wr = 1'b0; mask_clr_edge = 1'b0; irq_req = 5'b00000; cyc(2);

      // R2 R3 R4 unmaskable line
      tag = "R2";
      wr_mask(4'hF, 1'b0);
      pulse_take(); cyc();
      irq_req = 5'b10000; cyc(2);
      tag = "R8";
      pulse_take(); cyc();
      tag = "R3";
      cyc(3);
      irq_req = 5'b00000; cyc();
      irq_req = 5'b10000; cyc(2);
      tag = "R4";
      irq_req = 5'b00000; cyc(2);
      irq_req = 5'b10000; cyc(2);
      pulse_take(); irq_req = 5'b00000; cyc(2);

      // R9 device-addressed line with acknowledge
      tag = "R9";
      wr_mask(4'b1110, 1'b0); enable();
      irq_req = 5'b00001; cyc();
      take = 1'b1; cyc(); take = 1'b0;
      dev_addr = 16'hBEEF; take = 1'b1; cyc(); take = 1'b0;
      dev_addr = 16'h0000; cyc(2);
      enable(); dev_addr = 16'h1234;
      irq_req = 5'b10001; cyc(2);
      pulse_take(); cyc(2);
      irq_req = 5'b00001; enable(); pulse_take(); cyc(2);
      irq_req = 5'b00000; cyc(2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule